// File: doc/BRIEF.md
# Byte Misalignment Extraction Unit

This unit helps a datapath handle data that does not sit on an 8-byte boundary. It has two operations. The first is the align-address operation. It adds two 64-bit operands and returns the sum with its three low bits cleared, which is the 8-byte-aligned address. As a side effect, it stores a 3-bit byte offset in the low field of a 64-bit status register. In big-endian form the stored offset is the low three bits of the sum. In little-endian form it is the low three bits of the negated sum.

The second is the extract operation. It joins two 64-bit words into one 16-byte big-endian stream, with the first word in front. It then returns the eight consecutive bytes that start at the stored offset. Software normally issues one align-address operation, then a series of extract operations over adjacent aligned words.

The result is combinational. The status register updates on the clock edge that follows an issued align-address operation. Software can also write the status register as a whole and read it back.

Top module: `byte_align_unit`

## Requirements
- R1: With `op_sel_i`=0 (align-address), `result_o` equals `opa_i + opb_i` (modulo 2^64) with bits 2:0 forced to zero, in the same cycle.
- R2: An issued align-address operation (`op_valid_i`=1, `op_sel_i`=0) with `little_i`=0 loads `stat_o[2:0]` with bits 2:0 of `opa_i + opb_i` at the next rising clock edge.
- R3: The same operation with `little_i`=1 loads `stat_o[2:0]` with bits 2:0 of the two's-complement negation of `opa_i + opb_i`.
- R4: An align-address operation leaves `stat_o[63:3]` unchanged when no software write occurs in the same cycle.
- R5: With `op_sel_i`=1 (extract), `result_o` holds bytes k..k+7 of the 16-byte stream {`opa_i`,`opb_i`}, where k = `stat_o[2:0]`. Byte 0 of the stream is `opa_i[63:56]`, and lower-numbered bytes go to the more significant end of the result. `little_i` has no effect on extract.
- R6: An extract with `stat_o[2:0]`=0 returns `opa_i` unchanged, with nothing taken from `opb_i`.
- R7: `stat_o` is zero after reset (`rst_ni` low).
- R8: `stat_we_i`=1 loads all 64 bits of `stat_wdata_i` at the next edge. If an align-address operation is issued in the same cycle, bits 2:0 take the computed offset and the other bits take the write data.
- R9: `stat_o` does not change in a cycle with no write and either `op_valid_i`=0 or `op_sel_i`=1 (extract).

Of these, R1, R5 and R6 concern the combinational result. The others concern the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation issued this cycle (gates the offset update) |
| op_sel_i | input | 1 | 0 = align-address, 1 = extract |
| little_i | input | 1 | Little-endian offset variant for align-address |
| opa_i | input | 64 | First operand / leading stream word |
| opb_i | input | 64 | Second operand / trailing stream word |
| result_o | output | 64 | Aligned address or extracted word |
| stat_we_i | input | 1 | Status register write enable |
| stat_wdata_i | input | 64 | Status register write data |
| stat_o | output | 64 | Status register contents; bits 2:0 are the byte offset |

## Verification
`result_o` is due in the same cycle as its operands. It is sampled 1 time unit after the bench drives the inputs on the falling edge. The status register is due one rising edge after the operation or write. The bench samples it just after that edge, compares it with a shadow model, and only then drops the valid and write strobes. An extract that follows an align-address operation therefore sees the new offset only from the next cycle, and the expected extract result is always built from the shadow offset as it stood before that edge.

// File: rtl/balign_pkg.sv
package balign_pkg;
  typedef enum logic {
    OP_ALIGN   = 1'b0,
    OP_EXTRACT = 1'b1
  } balign_op_e;

  localparam int unsigned DEF_DATA_W = 64;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_STAT_W = 64;
endpackage

// File: rtl/balign_addr.sv
module balign_addr #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned OFS_W  = 3
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              little_i,
  output logic [DATA_W-1:0] aligned_o,
  output logic [OFS_W-1:0]  ofs_o
);
  logic [DATA_W-1:0] sum;
  logic [OFS_W-1:0]  neg_lo;

  assign sum       = opa_i + opb_i;
  assign aligned_o = {sum[DATA_W-1:OFS_W], {OFS_W{1'b0}}};
  // low bits of the negated sum only depend on low bits of the sum
  assign neg_lo    = {OFS_W{1'b0}} - sum[OFS_W-1:0];
  assign ofs_o     = little_i ? neg_lo : sum[OFS_W-1:0];
endmodule

// File: rtl/balign_funnel.sv
module balign_funnel #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned OFS_W  = 3
) (
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned NB  = DATA_W / BYTE_W;
  localparam int unsigned SNB = 2 * NB;

  logic [2*DATA_W-1:0] stream;
  logic [BYTE_W-1:0]   sbyte [SNB];

  assign stream = {hi_i, lo_i};

  // stream byte 0 is the most significant byte of hi_i
  for (genvar k = 0; k < SNB; k++) begin : g_split
    assign sbyte[k] = stream[2*DATA_W-1-k*BYTE_W -: BYTE_W];
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [OFS_W:0] LANE = (OFS_W+1)'(i);
    logic [OFS_W:0] idx;
    assign idx = LANE + {1'b0, ofs_i};
    assign data_o[DATA_W-1-i*BYTE_W -: BYTE_W] = sbyte[idx];
  end
endmodule

// File: rtl/balign_status.sv
module balign_status #(
  parameter int unsigned STAT_W = 64,
  parameter int unsigned OFS_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_ofs_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              we_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else begin
      if (we_i) stat_q <= wdata_i;
      // offset capture wins over a concurrent write for the low field
      if (set_ofs_i) stat_q[OFS_W-1:0] <= ofs_i;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/byte_align_unit.sv
module byte_align_unit
  import balign_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  parameter int unsigned STAT_W = DEF_STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic              op_sel_i,
  input  logic              little_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] result_o,
  input  logic              stat_we_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic [STAT_W-1:0] stat_o
);
  localparam int unsigned NB    = DATA_W / BYTE_W;
  localparam int unsigned OFS_W = $clog2(NB);

  balign_op_e        op;
  logic [DATA_W-1:0] aligned;
  logic [OFS_W-1:0]  new_ofs;
  logic [DATA_W-1:0] extracted;
  logic              set_ofs;

  assign op      = balign_op_e'(op_sel_i);
  assign set_ofs = op_valid_i && (op == OP_ALIGN);

  balign_addr #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_addr (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .little_i (little_i),
    .aligned_o(aligned),
    .ofs_o    (new_ofs)
  );

  balign_status #(.STAT_W(STAT_W), .OFS_W(OFS_W)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_ofs_i(set_ofs),
    .ofs_i    (new_ofs),
    .we_i     (stat_we_i),
    .wdata_i  (stat_wdata_i),
    .stat_o   (stat_o)
  );

  balign_funnel #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .OFS_W(OFS_W)) u_funnel (
    .hi_i  (opa_i),
    .lo_i  (opb_i),
    .ofs_i (stat_o[OFS_W-1:0]),
    .data_o(extracted)
  );

  assign result_o = (op == OP_EXTRACT) ? extracted : aligned;
endmodule

// File: rtl/balign_checker.sv
module balign_checker #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned STAT_W = 64,
  parameter int unsigned OFS_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic              op_sel_i,
  input logic              little_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [DATA_W-1:0] result_o,
  input logic              stat_we_i,
  input logic [STAT_W-1:0] stat_wdata_i,
  input logic [STAT_W-1:0] stat_o
);
  logic [DATA_W-1:0] sum_c;
  logic [DATA_W-1:0] neg_c;
  logic              align_go;

  assign sum_c    = opa_i + opb_i;
  assign neg_c    = -sum_c;
  assign align_go = op_valid_i && !op_sel_i;

  p_align_low_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_sel_i |-> (result_o[OFS_W-1:0] == '0 &&
                   result_o[DATA_W-1:OFS_W] == sum_c[DATA_W-1:OFS_W]));

  p_ofs_big_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_go && !little_i) |=> stat_o[OFS_W-1:0] == $past(sum_c[OFS_W-1:0]));

  p_ofs_little_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_go && little_i) |=> stat_o[OFS_W-1:0] == $past(neg_c[OFS_W-1:0]));

  p_upper_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_go && !stat_we_i) |=> $stable(stat_o[STAT_W-1:OFS_W]));

  p_zero_ofs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_sel_i && stat_o[OFS_W-1:0] == '0) |-> result_o == opa_i);

  p_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i |=> stat_o[STAT_W-1:OFS_W] == $past(stat_wdata_i[STAT_W-1:OFS_W]));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_we_i && !align_go) |=> $stable(stat_o));
endmodule

bind byte_align_unit balign_checker #(
  .DATA_W(DATA_W), .STAT_W(STAT_W), .OFS_W(OFS_W)
) u_balign_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_valid_i  (op_valid_i),
  .op_sel_i    (op_sel_i),
  .little_i    (little_i),
  .opa_i       (opa_i),
  .opb_i       (opb_i),
  .result_o    (result_o),
  .stat_we_i   (stat_we_i),
  .stat_wdata_i(stat_wdata_i),
  .stat_o      (stat_o)
);

// File: tb/tb_byte_align_unit.sv
module tb_byte_align_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic        op_sel_i = 1'b0;
  logic        little_i = 1'b0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic [63:0] result_o;
  logic        stat_we_i = 1'b0;
  logic [63:0] stat_wdata_i = '0;
  logic [63:0] stat_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [63:0] stat_m = '0;

  byte_align_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_sel_i(op_sel_i),
    .little_i(little_i), .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o),
    .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i), .stat_o(stat_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [2:0] f_ofs(input logic [63:0] a, input logic [63:0] b, input logic le);
    logic [63:0] s;
    s = a + b;
    if (le) s = ~s + 64'd1;
    return s[2:0];
  endfunction

  function automatic logic [63:0] f_extract(input logic [63:0] a, input logic [63:0] b, input logic [2:0] o);
    logic [127:0] st;
    st = {a, b} << (8 * o);
    return st[127:64];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus: comb result checked after drive, status after the edge
  task automatic issue(input logic valid, input logic sel, input logic le,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic we, input logic [63:0] wd, input string stag);
    logic [63:0] exp_r;
    @(negedge clk_i);
    op_valid_i = valid; op_sel_i = sel; little_i = le;
    opa_i = a; opb_i = b; stat_we_i = we; stat_wdata_i = wd;
    #1;
    if (sel) begin
      exp_r = f_extract(a, b, stat_m[2:0]);
      chk(stat_m[2:0] == 3'd0 ? "R6 zero offset extract" : "R5 extract", result_o, exp_r);
    end else begin
      exp_r = (a + b) & ~64'd7;
      chk("R1 aligned address", result_o, exp_r);
    end
    if (we) stat_m = wd;
    if (valid && !sel) stat_m[2:0] = f_ofs(a, b, le);
    @(posedge clk_i);
    #1;
    op_valid_i = 1'b0; stat_we_i = 1'b0;
    chk(stag, stat_o, stat_m);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    #(CLK_PERIOD * 2 + 1);
    chk("R7 reset state", stat_o, 64'd0);
    rst_ni = 1'b1;
    #(CLK_PERIOD);

    // R2 big-endian offset
    issue(1, 0, 0, 64'h1003, 64'h4, 0, '0, "R2 big-endian offset 7");
    // R3 little-endian: -(0x1007) low bits = 1
    issue(1, 0, 1, 64'h1003, 64'h4, 0, '0, "R3 little-endian offset 1");
    // R5 extract at offset 1
    issue(1, 1, 0, 64'h0011223344556677, 64'h8899AABBCCDDEEFF, 0, '0, "R9 extract leaves status");
    // R5 little_i ignored on extract
    issue(1, 1, 1, 64'h0011223344556677, 64'h8899AABBCCDDEEFF, 0, '0, "R9 extract little ignored");
    // R8 full write, then R4 upper preserved through align
    issue(0, 1, 0, 64'h0, 64'h0, 1, 64'hDEADBEEF_CAFEF00D, "R8 software write");
    issue(1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3, 0, '0, "R4 upper bits kept");
    issue(1, 1, 0, 64'hA1A2A3A4A5A6A7A8, 64'hB1B2B3B4B5B6B7B8, 0, '0, "R9 extract offset 2");
    // R8 write and align together
    issue(1, 0, 1, 64'h20, 64'h5, 1, 64'h0123456789ABCDEF, "R8 write with align");
    // R9 align not valid: no update
    issue(0, 0, 0, 64'h1, 64'h1, 0, '0, "R9 idle align");
    // R6 zero offset: align sum multiple of 8
    issue(1, 0, 0, 64'h100, 64'h8, 0, '0, "R2 offset zero");
    issue(1, 1, 0, 64'hCAFEBABE_12345678, 64'hFFFFFFFF_FFFFFFFF, 0, '0, "R9 extract hold");
    // R3 little-endian of aligned sum gives 0
    issue(1, 0, 1, 64'h10, 64'h0, 0, '0, "R3 little-endian offset 0");
    // offset 7 extract
    issue(1, 0, 0, 64'h7, 64'h0, 0, '0, "R2 offset 7");
    issue(1, 1, 0, 64'h0102030405060708, 64'h1112131415161718, 0, '0, "R9 extract offset 7");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b, wd;
      int kind;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      wd = {$urandom, $urandom};
      kind = int'($urandom_range(0, 5));
      case (kind)
        0: issue(1, 0, 0, a, b, 0, '0, "R2 random big-endian");
        1: issue(1, 0, 1, a, b, 0, '0, "R3 random little-endian");
        2, 3: issue(1'($urandom), 1, 1'($urandom), a, b, 0, '0, "R9 random extract");
        4: issue(1'($urandom), 0, 1'($urandom), a, b, 1, wd, "R8 random write");
        default: issue(0, 0, 1'($urandom), a, b, 0, '0, "R9 random idle");
      endcase
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule